// File: doc/BRIEF.md
# Floppy Data Rate Select Logic

This block holds the two-bit transfer rate code of a floppy disk controller. Two host register offsets can set it. One is the write-only configuration control register at offset 7, whose only live field is bits 1:0. The other is the data rate select register at offset 4, which carries the rate in the same two bits. The code keeps the value of the most recent write to either offset. The rest of the controller receives the code and a one-hot selection of the matching bit-rate clock.

Several host ports share the block. Each port has its own write strobe, read strobe, address and data. Each port decodes its own address. When several ports write in the same cycle, a write to the data rate select offset beats a write to the configuration control offset. Among writes to the same offset, the lowest port index wins.

A hardware reset is synchronous and active high. It forces the code to 250 Kbps (binary 10). A software reset leaves the code as it is. Reading the write-only configuration offset returns the idle bus value and changes nothing.

Top module: `fdc_rate_sel`

## Requirements
- R1: A write to offset 7 loads wdata bits 1:0 into rate_code, visible in the cycle after the strobe.
- R2: Bits 7:2 of a write to offset 7 have no effect: the resulting rate_code depends only on bits 1:0.
- R3: A write to offset 4 loads wdata bits 1:0 into rate_code, visible in the cycle after the strobe.
- R4: rate_code equals the value of the most recent accepted write, whichever of offsets 4 and 7 it went to.
- R5: In one cycle, any write to offset 4 beats any write to offset 7. Among writes to the same offset, the lowest port index wins.
- R6: Writes to any offset other than 4 and 7 leave rate_code unchanged.
- R7: A cycle with rst high sets rate_code to 2'b10 in the next cycle, overriding any write in that cycle.
- R8: soft_rst leaves rate_code unchanged. A write accepted in the same cycle still takes effect.
- R9: rate_sel is one-hot with bit index equal to rate_code: bit0 = 500 Kbps (00), bit1 = 300 Kbps (01), bit2 = 250 Kbps (10), bit3 = 1 Mbps (11).
- R10: On a port reading offset 7, host_rdata is 8'hFF in the same cycle and rate_code is not changed. A port not reading offset 7 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Software reset pulse; does not touch the rate |
| host_wr | input | NP | Per-port write strobe |
| host_rd | input | NP | Per-port read strobe |
| host_addr | input | NP x ADDR_W | Per-port register offset |
| host_wdata | input | NP x 8 | Per-port write data |
| host_rdata | output | NP x 8 | Per-port read data |
| rate_code | output | 2 | Active rate code |
| rate_sel | output | 4 | One-hot rate clock selection |

## Verification
The bench builds the block with its defaults: two host ports, a three-bit offset, the configuration offset at 7 and the rate select offset at 4. With two ports, one cycle can carry every collision the priority rule covers: rate select against configuration, and two writes to the same offset. Random traffic adds soft resets, hardware resets arriving alongside writes, and accesses to unrelated offsets.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_e;

    localparam int RATE_COUNT = 4;

    // Decoded request of one host port for the current cycle
    typedef struct packed {
        logic  cfg_hit;   // write to the configuration control offset
        logic  sel_hit;   // write to the data rate select offset
        rate_e code;      // rate field carried by the write
    } port_req_t;

    function automatic logic [RATE_COUNT-1:0] rate_onehot(input rate_e code);
        logic [RATE_COUNT-1:0] v;
        v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/fdc_rate_port_dec.sv
module fdc_rate_port_dec
    import fdc_rate_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int CFG_OFS = 7,
    parameter int SEL_OFS = 4,
    parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output port_req_t         req,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);

    always_comb begin
        req.cfg_hit = wr && (addr == CFG_A);
        req.sel_hit = wr && (addr == SEL_A);
        req.code    = rate_e'(wdata[1:0]);
    end

    // The configuration offset cannot be read: it returns the idle bus value
    assign rdata = (rd && (addr == CFG_A)) ? IDLE_VAL : '0;

    // Reserved bits above the rate field are discarded
    logic wdata_unused;
    assign wdata_unused = ^wdata[DATA_W-1:2];

endmodule

// File: rtl/fdc_rate_arb.sv
module fdc_rate_arb
    import fdc_rate_pkg::*;
#(
    parameter int NP = 2
) (
    input  port_req_t [NP-1:0] reqs,
    output logic               upd,
    output rate_e              nxt
);
    always_comb begin
        logic  cfg_any;
        logic  sel_any;
        rate_e cfg_code;
        rate_e sel_code;
        cfg_any  = 1'b0;
        sel_any  = 1'b0;
        cfg_code = RATE_500K;
        sel_code = RATE_500K;
        // Scan from the top so the lowest index is assigned last and wins
        for (int i = NP - 1; i >= 0; i--) begin
            if (reqs[i].cfg_hit) begin
                cfg_any  = 1'b1;
                cfg_code = reqs[i].code;
            end
            if (reqs[i].sel_hit) begin
                sel_any  = 1'b1;
                sel_code = reqs[i].code;
            end
        end
        upd = cfg_any || sel_any;
        nxt = sel_any ? sel_code : cfg_code;
    end

endmodule

// File: rtl/fdc_rate_reg.sv
module fdc_rate_reg
    import fdc_rate_pkg::*;
#(
    parameter rate_e HW_CODE = RATE_250K
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  rate_e nxt,
    output rate_e q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= HW_CODE;
        else if (upd)
            q <= nxt;
    end

endmodule

// File: rtl/fdc_rate_sel.sv
module fdc_rate_sel
    import fdc_rate_pkg::*;
#(
    parameter int NP = 2,
    parameter int ADDR_W = 3,
    parameter int CFG_OFS = 7,
    parameter int SEL_OFS = 4,
    parameter logic [7:0] IDLE_VAL = 8'hFF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        soft_rst,
    input  logic [NP-1:0]               host_wr,
    input  logic [NP-1:0]               host_rd,
    input  logic [NP-1:0][ADDR_W-1:0]   host_addr,
    input  logic [NP-1:0][7:0]          host_wdata,
    output logic [NP-1:0][7:0]          host_rdata,
    output logic [1:0]                  rate_code,
    output logic [RATE_COUNT-1:0]       rate_sel
);
    port_req_t [NP-1:0] reqs;
    logic  upd;
    rate_e nxt;
    rate_e cur;

    for (genvar p = 0; p < NP; p++) begin : g_port
        fdc_rate_port_dec #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (8),
            .CFG_OFS (CFG_OFS),
            .SEL_OFS (SEL_OFS),
            .IDLE_VAL(IDLE_VAL)
        ) dec_i (
            .wr   (host_wr[p]),
            .rd   (host_rd[p]),
            .addr (host_addr[p]),
            .wdata(host_wdata[p]),
            .req  (reqs[p]),
            .rdata(host_rdata[p])
        );
    end

    fdc_rate_arb #(.NP(NP)) arb_i (
        .reqs(reqs),
        .upd (upd),
        .nxt (nxt)
    );

    fdc_rate_reg #(.HW_CODE(RATE_250K)) reg_i (
        .clk(clk),
        .rst(rst),
        .upd(upd),
        .nxt(nxt),
        .q  (cur)
    );

    assign rate_code = cur;
    assign rate_sel  = rate_onehot(cur);

    // The rate field survives a software reset, so the pulse is not consumed here
    logic soft_rst_unused;
    assign soft_rst_unused = soft_rst;

endmodule

// File: rtl/fdc_rate_sel_chk.sv
module fdc_rate_sel_chk #(
    parameter int NP = 2,
    parameter int ADDR_W = 3,
    parameter int CFG_OFS = 7,
    parameter int SEL_OFS = 4,
    parameter logic [7:0] IDLE_VAL = 8'hFF
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      soft_rst,
    input logic [NP-1:0]             host_wr,
    input logic [NP-1:0]             host_rd,
    input logic [NP-1:0][ADDR_W-1:0] host_addr,
    input logic [NP-1:0][7:0]        host_wdata,
    input logic [NP-1:0][7:0]        host_rdata,
    input logic [1:0]                rate_code,
    input logic [3:0]                rate_sel
);
    logic [NP-1:0] cfg_w;
    logic [NP-1:0] sel_w;
    logic [NP-1:0] cfg_r;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            cfg_w[i] = host_wr[i] && (host_addr[i] == ADDR_W'(CFG_OFS));
            sel_w[i] = host_wr[i] && (host_addr[i] == ADDR_W'(SEL_OFS));
            cfg_r[i] = host_rd[i] && (host_addr[i] == ADDR_W'(CFG_OFS));
        end
    end

    logic chk_unused;
    assign chk_unused = ^host_wdata;

    // R1: lone configuration write on port 0
    a_r1_cfg_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_w[0] && (sel_w == '0) && ((cfg_w >> 1) == '0))
        |=> rate_code == $past(host_wdata[0][1:0]));

    // R3 and R5: a rate select write on port 0 always wins
    a_r3_sel_load: assert property (@(posedge clk) disable iff (rst)
        sel_w[0] |=> rate_code == $past(host_wdata[0][1:0]));

    // R6: without any write to either offset the code holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        ((cfg_w == '0) && (sel_w == '0)) |=> $stable(rate_code));

    // R8: a software reset alone leaves the code in place
    a_r8_soft_keep: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && (cfg_w == '0) && (sel_w == '0)) |=> $stable(rate_code));

    // R7: hardware reset forces 250 Kbps
    a_r7_hw_reset: assert property (@(posedge clk)
        rst |=> rate_code == 2'b10);

    // R9: selection is one-hot and points at the code
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(rate_sel) == 1) && rate_sel[rate_code]);

    // R10: read data per port
    for (genvar p = 0; p < NP; p++) begin : g_rd
        a_r10_read_idle: assert property (@(posedge clk) disable iff (rst)
            host_rdata[p] == (cfg_r[p] ? IDLE_VAL : 8'h00));
    end

endmodule

bind fdc_rate_sel fdc_rate_sel_chk #(
    .NP      (NP),
    .ADDR_W  (ADDR_W),
    .CFG_OFS (CFG_OFS),
    .SEL_OFS (SEL_OFS),
    .IDLE_VAL(IDLE_VAL)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .rate_code (rate_code),
    .rate_sel  (rate_sel)
);

// File: tb/fdc_rate_sel_tb_top.sv
`timescale 1ns/1ps
module fdc_rate_sel_tb_top;
    localparam int NP = 2;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0;
    logic [NP-1:0]         host_wr = '0;
    logic [NP-1:0]         host_rd = '0;
    logic [NP-1:0][AW-1:0] host_addr = '0;
    logic [NP-1:0][7:0]    host_wdata = '0;
    logic [NP-1:0][7:0]    host_rdata;
    logic [1:0]            rate_code;
    logic [3:0]            rate_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] exp_code = 2'b10;
    int unsigned seed = 32'h5eed_1234;

    always #5 clk = ~clk;

    fdc_rate_sel dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rate_code(rate_code), .rate_sel(rate_sel)
    );

    function automatic logic [1:0] model_next(input logic [1:0] cur);
        if (rst) return 2'b10;
        for (int i = 0; i < NP; i++)
            if (host_wr[i] && host_addr[i] == 3'd4) return host_wdata[i][1:0];
        for (int i = 0; i < NP; i++)
            if (host_wr[i] && host_addr[i] == 3'd7) return host_wdata[i][1:0];
        return cur;
    endfunction

    function automatic logic [7:0] model_rd(input int p);
        return (host_rd[p] && host_addr[p] == 3'd7) ? 8'hFF : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst = 1'b0; soft_rst = 1'b0; host_wr = '0; host_rd = '0;
        host_addr = '0; host_wdata = '0;
    endtask

    // Inputs are set just after a rising edge; apply them over one edge and check
    task automatic step(input string tag);
        logic [1:0] nxt;
        #2;
        for (int p = 0; p < NP; p++) check({tag, " R10 rdata"}, host_rdata[p], model_rd(p));
        nxt = model_next(exp_code);
        @(posedge clk); #1;
        exp_code = nxt;
        check({tag, " code"}, rate_code, exp_code);
        check({tag, " R9 sel"}, rate_sel, 4'b0001 << exp_code);
        idle_inputs();
    endtask

    task automatic wr1(input int p, input logic [2:0] a, input logic [7:0] d);
        host_wr[p] = 1'b1; host_addr[p] = a; host_wdata[p] = d;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R7 reset code", rate_code, 2'b10);
        check("R9 reset sel", rate_sel, 4'b0100);
        idle_inputs();

        wr1(0, 3'd7, 8'h03);               step("R1 cfg write 11");
        wr1(0, 3'd7, 8'hFC);               step("R2 reserved ones 00");
        wr1(1, 3'd7, 8'hA9);               step("R2 reserved mix 01");
        wr1(0, 3'd4, 8'h02);               step("R3 sel write 10");
        wr1(1, 3'd7, 8'h03);               step("R4 cfg after sel");
        wr1(1, 3'd4, 8'h00);               step("R4 sel after cfg");
        wr1(0, 3'd7, 8'h03); wr1(1, 3'd4, 8'h01); step("R5 sel beats cfg");
        wr1(0, 3'd4, 8'h00); wr1(1, 3'd4, 8'h03); step("R5 low port sel");
        wr1(0, 3'd7, 8'h02); wr1(1, 3'd7, 8'h03); step("R5 low port cfg");
        wr1(0, 3'd5, 8'h03); wr1(1, 3'd0, 8'h01); step("R6 other offsets");
        soft_rst = 1'b1;                   step("R8 soft alone");
        soft_rst = 1'b1; wr1(0, 3'd7, 8'h03); step("R8 soft with write");
        rst = 1'b1; wr1(0, 3'd4, 8'h01);   step("R7 reset beats write");
        host_rd[0] = 1'b1; host_addr[0] = 3'd7; step("R10 read cfg");
        host_rd[1] = 1'b1; host_addr[1] = 3'd4; step("R10 read other");
        for (int c = 0; c < 4; c++) begin
            wr1(0, 3'd4, 8'(c));           step("R9 walk");
        end

        for (int n = 0; n < 600; n++) begin
            rst      = ($urandom(seed) % 40) == 0;
            soft_rst = ($urandom(seed) % 8) == 0;
            for (int p = 0; p < NP; p++) begin
                int unsigned r;
                r = $urandom(seed) % 8;
                host_wr[p]    = ($urandom(seed) % 3) == 0;
                host_rd[p]    = ($urandom(seed) % 3) == 0;
                host_addr[p]  = (r < 3) ? 3'd7 : (r < 6) ? 3'd4 : 3'($urandom(seed));
                host_wdata[p] = 8'($urandom(seed));
            end
            step("R4 random");
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule